// File: doc/BRIEF.md
# Tagged Conversion Result FIFO

This block queues signed results coming out of a converter front end and hands them back one per read as 16-bit words. Every write brings a sign bit, a 12-bit magnitude, the 3-bit number of the instruction that produced the sample, and a flag saying whether the sample is a short (8-bit) one. The block packs these fields into a read word as the write is accepted. A per-write option controls the top three bits of that word. They hold either the instruction tag or copies of the sign, so that software can read the word directly as a two's complement number.

Reads pop the oldest entry. The word appears on the data output in the cycle after the read request. A 5-bit output reports how many accepted results have not yet been read. Writes that arrive while the queue is full are discarded and flagged. Reads that arrive while it is empty return zero.

Top module: `tagged_result_fifo`

## Requirements
- R1: Bit 12 of every read word equals the sign bit of the write that stored it (0 positive, 1 negative).
- R2: For a write with `wr_short` low, bits 11..0 of the read word equal `wr_mag[11:0]`.
- R3: For a write with `wr_short` high, bits 11..4 equal `wr_mag[11:4]` and bits 3..0 are binary 1110.
- R4: For a write with `cfg_sign_ext` low, bits 15..13 equal `wr_tag`.
- R5: For a write with `cfg_sign_ext` high, bits 15..13 are all equal to the sign bit.
- R6: `wr_short` and `cfg_sign_ext` are sampled per write, so entries written under different settings keep their own formats.
- R7: Entries are read in write order. A read requested in cycle N shows its word on `rd_data` after clock edge N, and `rd_data` holds that value until the next read.
- R8: `unread_cnt` equals the number of accepted writes minus the number of successful reads, and is updated at the clock edge that completes them.
- R9: The queue holds 31 entries. A write while 31 entries are held is dropped, and `overflow` is high for exactly the following cycle. `overflow` is low at all other times.
- R10: A read while the queue is empty puts 0 on `rd_data` and does not change `unread_cnt`.
- R11: A write and a read in the same cycle leave `unread_cnt` unchanged when 1 to 30 entries are held. When the queue is empty, the write is accepted and the read returns 0. When the queue is full, the read pops, the write is dropped with `overflow`, and the count falls by one.
- R12: A synchronous reset (`rst` high at a clock edge) empties the queue and sets `unread_cnt`, `rd_data` and `overflow` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write request |
| wr_sign | input | 1 | Sign of the result |
| wr_mag | input | 12 | Result magnitude field |
| wr_tag | input | 3 | Originating instruction number |
| wr_short | input | 1 | 1 = 8-bit result format |
| cfg_sign_ext | input | 1 | 1 = sign extension in bits 15..13 |
| rd_en | input | 1 | Read (pop) request |
| rd_data | output | 16 | Formatted result word (registered) |
| unread_cnt | output | 5 | Number of unread entries |
| overflow | output | 1 | One-cycle pulse after a dropped write |

## Verification
The hardest states to reach are the ones at the capacity limit. The stimulus first fills all 31 entries with mixed formats. It then offers a lone write to provoke the overflow pulse, and then a write together with a read while the queue is still full, so that the pop and the drop happen in the same edge. It then drains the queue and issues a combined write and read at zero entries. Finally it resets the block while entries are still queued, to show that nothing left over from before the reset is returned.

// File: rtl/tfifo_pkg.sv
package tfifo_pkg;
  localparam int WORD_W = 16;
  localparam int MAG_W  = 12;
  localparam int TAG_W  = 3;
  localparam logic [3:0] SHORT_PAD = 4'b1110;

  typedef struct packed {
    logic             sign;
    logic [MAG_W-1:0] mag;
    logic [TAG_W-1:0] tag;
    logic             short_fmt;
  } sample_t;
endpackage

// File: rtl/tfifo_fmt.sv
module tfifo_fmt
  import tfifo_pkg::*;
(
  input  sample_t           smp,
  input  logic              sign_ext,
  output logic [WORD_W-1:0] word
);
  logic [TAG_W-1:0] top_bits;
  logic [MAG_W-1:0] low_bits;

  always_comb begin
    top_bits = sign_ext ? {TAG_W{smp.sign}} : smp.tag;
    low_bits = smp.short_fmt ? {smp.mag[MAG_W-1:4], SHORT_PAD} : smp.mag;
    word     = {top_bits, smp.sign, low_bits};
  end
endmodule

// File: rtl/tfifo_ctrl.sv
module tfifo_ctrl #(
  parameter int DEPTH = 31,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          rd_en,
  output logic          wr_ok,
  output logic          rd_ok,
  output logic [AW-1:0] wr_addr,
  output logic [AW-1:0] rd_addr,
  output logic [CW-1:0] count,
  output logic          overflow
);
  logic          full, empty;
  logic [AW-1:0] wr_nxt, rd_nxt;

  assign full  = (count == CW'(DEPTH));
  assign empty = (count == '0);
  assign wr_ok = wr_en & ~full;
  assign rd_ok = rd_en & ~empty;

  generate
    if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
      assign wr_nxt = wr_addr + 1'b1;
      assign rd_nxt = rd_addr + 1'b1;
    end else begin : g_wrap
      assign wr_nxt = (wr_addr == AW'(DEPTH - 1)) ? '0 : wr_addr + 1'b1;
      assign rd_nxt = (rd_addr == AW'(DEPTH - 1)) ? '0 : rd_addr + 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_addr  <= '0;
      rd_addr  <= '0;
      count    <= '0;
      overflow <= 1'b0;
    end else begin
      overflow <= wr_en & full;
      if (wr_ok) wr_addr <= wr_nxt;
      if (rd_ok) rd_addr <= rd_nxt;
      case ({wr_ok, rd_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R8
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));
  // R9
  ovf_cause_chk: assert property (@(posedge clk) disable iff (rst)
    overflow |-> ($past(wr_en) && $past(count) == CW'(DEPTH)));
  // R11
  cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && rd_en && count != '0 && count != CW'(DEPTH)) |=> $stable(count));
  // R10
  empty_read_cnt_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !wr_en && count == '0) |=> count == '0);
endmodule

// File: rtl/tfifo_mem.sv
module tfifo_mem #(
  parameter int DEPTH = 31,
  parameter int W     = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          re,
  input  logic          re_ok,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  q
);
  logic [W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (re) q <= re_ok ? store[raddr] : '0;
  end

  // R10
  zero_on_empty_chk: assert property (@(posedge clk) disable iff (rst)
    (re && !re_ok) |=> q == '0);
  // R7
  hold_q_chk: assert property (@(posedge clk) disable iff (rst)
    !re |=> $stable(q));
endmodule

// File: rtl/tagged_result_fifo.sv
module tagged_result_fifo
  import tfifo_pkg::*;
#(
  parameter int DEPTH = 31,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              wr_sign,
  input  logic [MAG_W-1:0]  wr_mag,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic              wr_short,
  input  logic              cfg_sign_ext,
  input  logic              rd_en,
  output logic [WORD_W-1:0] rd_data,
  output logic [CW-1:0]     unread_cnt,
  output logic              overflow
);
  sample_t           smp;
  logic [WORD_W-1:0] packed_word;
  logic              wr_ok, rd_ok;
  logic [AW-1:0]     wr_addr, rd_addr;

  assign smp = '{sign: wr_sign, mag: wr_mag, tag: wr_tag, short_fmt: wr_short};

  tfifo_fmt u_fmt (
    .smp      (smp),
    .sign_ext (cfg_sign_ext),
    .word     (packed_word)
  );

  tfifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .wr_ok    (wr_ok),
    .rd_ok    (rd_ok),
    .wr_addr  (wr_addr),
    .rd_addr  (rd_addr),
    .count    (unread_cnt),
    .overflow (overflow)
  );

  tfifo_mem #(.DEPTH(DEPTH), .W(WORD_W)) u_mem (
    .clk   (clk),
    .rst   (rst),
    .we    (wr_ok),
    .waddr (wr_addr),
    .wdata (packed_word),
    .re    (rd_en),
    .re_ok (rd_ok),
    .raddr (rd_addr),
    .q     (rd_data)
  );
endmodule

// File: tb/test_tagged_result_fifo.sv
`timescale 1ns/1ps
module test_tagged_result_fifo;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, wr_sign = 1'b0, wr_short = 1'b0, cfg_sign_ext = 1'b0, rd_en = 1'b0;
  logic [11:0] wr_mag = '0;
  logic [2:0]  wr_tag = '0;
  logic [15:0] rd_data;
  logic [4:0]  unread_cnt;
  logic        overflow;

  always #4 clk = ~clk;

  tagged_result_fifo i_tagged_result_fifo (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sign(wr_sign), .wr_mag(wr_mag),
    .wr_tag(wr_tag), .wr_short(wr_short), .cfg_sign_ext(cfg_sign_ext),
    .rd_en(rd_en), .rd_data(rd_data), .unread_cnt(unread_cnt), .overflow(overflow)
  );

  typedef struct {
    bit          chk_rd;
    logic [15:0] rd;
    logic [4:0]  cnt;
    bit          ovf;
    string       tag;
  } exp_t;

  exp_t        expq[$];
  logic [15:0] model[$];
  string       cur_tag = "R12";
  int          vectors = 0;
  int          fails = 0;
  bit          finished = 0;

  function automatic logic [15:0] fmt(bit s, logic [11:0] m, logic [2:0] t, bit sh, bit sx);
    logic [2:0]  top;
    logic [11:0] low;
    top = sx ? {3{s}} : t;
    low = sh ? {m[11:4], 4'b1110} : m;
    return {top, s, low};
  endfunction

  // driver: applies one cycle of stimulus and queues what the ports must show after it
  task automatic cycle(bit r, bit we, bit s, logic [11:0] m, logic [2:0] t, bit sh, bit sx, bit re);
    exp_t e;
    bit   rok, wok;
    rst = r; wr_en = we; wr_sign = s; wr_mag = m; wr_tag = t;
    wr_short = sh; cfg_sign_ext = sx; rd_en = re;
    e.tag = cur_tag;
    e.chk_rd = re || r;
    if (r) begin
      model.delete();
      e.rd = '0; e.cnt = '0; e.ovf = 0;
    end else begin
      rok = re && model.size() > 0;
      wok = we && model.size() < 31;
      e.rd = rok ? model.pop_front() : 16'h0000;
      if (wok) model.push_back(fmt(s, m, t, sh, sx));
      e.ovf = we && !wok;
      e.cnt = 5'(model.size());
    end
    @(posedge clk);
    #1;
    expq.push_back(e);
  endtask

  task automatic wr(bit s, logic [11:0] m, logic [2:0] t, bit sh, bit sx);
    cycle(0, 1, s, m, t, sh, sx, 0);
  endtask
  task automatic rd();
    cycle(0, 0, 0, '0, '0, 0, 0, 1);
  endtask
  task automatic idle();
    cycle(0, 0, 0, '0, '0, 0, 0, 0);
  endtask

  // monitor: compares ports against the scoreboard away from the active edge
  always @(negedge clk) begin
    if (expq.size() > 0) begin
      exp_t e;
      e = expq.pop_front();
      vectors++;
      if (unread_cnt !== e.cnt) begin
        fails++;
        $display("FAIL %s unread_cnt got %0d exp %0d", e.tag, unread_cnt, e.cnt);
      end
      vectors++;
      if (overflow !== e.ovf) begin
        fails++;
        $display("FAIL %s overflow got %0b exp %0b", e.tag, overflow, e.ovf);
      end
      if (e.chk_rd) begin
        vectors++;
        if (rd_data !== e.rd) begin
          fails++;
          $display("FAIL %s rd_data got %h exp %h", e.tag, rd_data, e.rd);
        end
      end
    end
  end

  initial begin
    // R12 reset state
    cur_tag = "R12";
    cycle(1, 0, 0, '0, '0, 0, 0, 0);
    cycle(1, 1, 1, 12'hFFF, 3'd7, 0, 0, 1);
    // R1 R2 R4: 12-bit words with instruction tags, R7 order
    cur_tag = "R1_R2_R4";
    wr(0, 12'h5A3, 3'd1, 0, 0);
    wr(1, 12'h0F0, 3'd6, 0, 0);
    wr(0, 12'hFFF, 3'd0, 0, 0);
    wr(1, 12'h001, 3'd7, 0, 0);
    cur_tag = "R7";
    repeat (4) rd();
    // R3 short format, R5 sign extension, R6 per-write sampling
    cur_tag = "R3_R5";
    wr(1, 12'hABC, 3'd2, 1, 1);
    wr(0, 12'h37F, 3'd5, 1, 0);
    wr(1, 12'h812, 3'd3, 0, 1);
    wr(0, 12'h812, 3'd3, 0, 1);
    cur_tag = "R6";
    wr(1, 12'h456, 3'd4, 0, 0);
    wr(1, 12'h456, 3'd4, 1, 1);
    repeat (6) rd();
    idle();
    // R10 empty read
    cur_tag = "R10";
    rd();
    rd();
    // R9 fill to capacity then overflow
    cur_tag = "R8";
    for (int i = 0; i < 31; i++)
      wr(bit'(i % 2), 12'(i * 97 + 5), 3'(i), (i % 3) == 0, (i % 4) == 1);
    cur_tag = "R9";
    wr(1, 12'h111, 3'd1, 0, 0);
    idle();
    // R11 simultaneous at full
    cur_tag = "R11";
    cycle(0, 1, 0, 12'h222, 3'd2, 0, 0, 1);
    cur_tag = "R7";
    repeat (30) rd();
    // R11 simultaneous at empty, then partial
    cur_tag = "R11";
    cycle(0, 1, 1, 12'h9C4, 3'd5, 0, 0, 1);
    wr(0, 12'h333, 3'd3, 1, 0);
    cycle(0, 1, 1, 12'h444, 3'd4, 0, 1, 1);
    cycle(0, 1, 0, 12'h555, 3'd6, 1, 1, 1);
    repeat (3) rd();
    // R12 reset with entries held
    cur_tag = "R12";
    wr(1, 12'h777, 3'd7, 0, 0);
    wr(0, 12'h666, 3'd6, 0, 0);
    cycle(1, 0, 0, '0, '0, 0, 0, 0);
    rd();
    wr(0, 12'h123, 3'd2, 0, 0);
    rd();
    repeat (3) idle();
    @(posedge clk);
    @(posedge clk);
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      finished = 1;
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule